// File: doc/BRIEF.md
# NAND Flash Bus Address Decoder

This block sits between a memory-mapped host bus window and two NAND flash slots. Each host access carries a full byte address. A three-bit field in the high address bits selects the first flash slot, the second flash slot, or a small bank of 16-bit registers. Two low address bits mark a flash write as a command byte or an address byte. A write with neither bit set is a plain data byte. The block turns each access into registered pin-level strobes: a per-slot chip enable, the command and address latch enables, and the write and read strobes. It also drives the outgoing data byte and its output enable.

The register bank holds one status word. Bit 0 of that word shows the ready/busy pin of the flash device that was selected most recently. Each ready/busy pin passes through a two-flop synchroniser before it reaches the status word. Host wait-state timing and the flash command protocol are handled elsewhere. The host holds `hst_sel` high for the whole strobe of an access, and the pins follow it one clock later.

Top module: `nand_bus_decoder`

## Requirements
- R1: Address bits 24..22 select the target. Code 3'b010 drives `fl_ce_n[0]` low (slot 0). Code 3'b011 drives `fl_ce_n[1]` low (slot 1). Code 3'b100 selects the register bank and leaves both chip enables high.
- R2: Any other code in bits 24..22 leaves every chip enable, latch enable and strobe inactive, and reads back 16'h0000.
- R3: A flash write with address bit 5 set drives `fl_cle` high and `fl_we_n` low, with `fl_ale` low.
- R4: A flash write with bit 4 set and bit 5 clear drives `fl_ale` high. When bits 5 and 4 are both set, only `fl_cle` is asserted.
- R5: A flash access with bits 5 and 4 clear is a data transfer. A write drives `fl_dq_oe` high and puts `hst_wdata` on `fl_dq_out`. A read drives `fl_re_n` low and returns {8'h00, `fl_dq_in`} on `hst_rdata`. Reads never assert `fl_cle` or `fl_ale`, and `fl_dq_out` is 8'h00 whenever `fl_dq_oe` is low.
- R6: In the register bank, the status word is at byte offset 0x2. Its word index is address bits 7..1 equal to 1; bit 0 and bits 21..8 are ignored. A read of the status word returns the ready flag in bit 0 (1 = ready, 0 = busy) and zeros elsewhere. Reads of any other offset return 16'h0000. Register writes move no flash pin.
- R7: The status word reports the slot of the most recent flash access, in either direction. After reset this is slot 0.
- R8: A change on `fl_rdy` first shows in a held status read after the second rising clock edge that follows it, and not after the first.
- R9: The pins reflect an access from the first rising edge at which `hst_sel` is sampled high. They stay stable while `hst_sel` stays high, and return to idle at the first edge at which it is sampled low.
- R10: In reset, and whenever idle, the outputs are: chip enables and strobes high, latch enables low, `fl_dq_oe` low, `hst_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_sel | input | 1 | Host access active, held for the strobe |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 25 | Host byte address |
| hst_wdata | input | 8 | Host write data byte |
| hst_rdata | output | 16 | Host read data |
| fl_ce_n | output | 2 | Per-slot chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_out | output | 8 | Data byte to flash |
| fl_dq_oe | output | 1 | Output enable for `fl_dq_out` |
| fl_dq_in | input | 8 | Data byte from flash |
| fl_rdy | input | 2 | Per-slot ready/busy, 1 = ready |

## Verification
Random accesses cover all eight select codes with random latch bits, direction, data and offset. Together they separate slot decode, register decode and the "no target" case, and they check the latch-enable priority on every write. Directed cases set both latch bits at once, read the status word at an odd byte offset, and write to the register bank. They also hold one access over several cycles and read status after accesses to each slot, which shows which slot the status word tracks. A held status read with `fl_rdy` toggled shows the two-edge synchroniser latency. Comparing the result one edge early and one edge later separates a correct two-flop path from a one-flop or three-flop path.

// File: rtl/nbd_pkg.sv
// Shared types and address-field constants for the NAND bus decoder.
// Assumes a byte-addressed host window whose top bits form the target code.
package nbd_pkg;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_FLASH = 2'd1,
        KIND_REGS  = 2'd2
    } nbd_kind_e;

    localparam int CLE_BIT = 5;   // address bit that marks a command write
    localparam int ALE_BIT = 4;   // address bit that marks an address write
    localparam int SEL_LSB = 22;  // lowest bit of the target code
    localparam int SEL_W   = 3;   // width of the target code
    localparam int OFS_MSB = 7;   // top bit of the register byte offset

endpackage

// File: rtl/nbd_addr_decode.sv
// Combinational decode of a host address into a target kind, slot index,
// latch-enable requests and a status-register hit.
// Assumes: slot codes are contiguous starting at SLOT_CODE0; the register
// bank has its own code; bit 0 of the offset is ignored (word access).
module nbd_addr_decode
    import nbd_pkg::*;
#(
    parameter int AW         = 25,
    parameter int NSLOT      = 2,
    parameter int SLOT_CODE0 = 2,
    parameter int REG_CODE   = 4,
    parameter int STAT_WORD  = 1,
    localparam int SLW       = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [AW-1:0]  addr,
    input  logic           wr,
    output nbd_kind_e      kind,
    output logic [SLW-1:0] slot_idx,
    output logic           cle_req,
    output logic           ale_req,
    output logic           status_hit
);

    localparam logic [SEL_W-1:0]   CODE0_V = SEL_W'(SLOT_CODE0);
    localparam logic [SEL_W-1:0]   NSLOT_V = SEL_W'(NSLOT);
    localparam logic [SEL_W-1:0]   REG_V   = SEL_W'(REG_CODE);
    localparam logic [OFS_MSB-1:0] STAT_V  = OFS_MSB'(STAT_WORD);

    logic [SEL_W-1:0] code;
    logic [SEL_W-1:0] rel;
    logic             unused_addr;

    assign code        = addr[SEL_LSB +: SEL_W];
    assign rel         = code - CODE0_V;
    assign unused_addr = ^{addr[AW-1:SEL_LSB+SEL_W], addr[SEL_LSB-1:OFS_MSB+1],
                           addr[ALE_BIT-1:0]};

    // Classify the target code.
    always_comb begin
        kind     = KIND_NONE;
        slot_idx = rel[SLW-1:0];
        if (code >= CODE0_V && rel < NSLOT_V) begin
            kind = KIND_FLASH;
        end else if (code == REG_V) begin
            kind = KIND_REGS;
        end
    end

    // Latch requests: command bit has priority over address bit, writes only.
    always_comb begin
        cle_req = wr && addr[CLE_BIT];
        ale_req = wr && addr[ALE_BIT] && !addr[CLE_BIT];
    end

    // Status hit: a register read whose word index is the status word.
    always_comb begin
        status_hit = (kind == KIND_REGS) && !wr && (addr[OFS_MSB:1] == STAT_V);
    end

endmodule

// File: rtl/nbd_rdy_sync.sv
// Two-flop synchroniser for each slot's ready/busy pin.
// Assumes the pins are asynchronous to clk and change slowly.
module nbd_rdy_sync #(
    parameter int NSLOT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] rdy_async,
    output logic [NSLOT-1:0] rdy_sync
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one slot's ready pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= rdy_async[g];
                stab_q <= meta_q;
            end
        end

        assign rdy_sync[g] = stab_q;
    end

endmodule

// File: rtl/nbd_strobe_gen.sv
// Registers the decoded access into flash pins and read-path state.
// Assumes hst_sel is held high for the full strobe; pins follow one clock
// later and return to idle one clock after hst_sel drops.
module nbd_strobe_gen
    import nbd_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int DQ_W  = 8,
    localparam int SLW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  nbd_kind_e        kind,
    input  logic [SLW-1:0]   slot_idx,
    input  logic             cle_req,
    input  logic             ale_req,
    input  logic             status_hit,
    input  logic [DQ_W-1:0]  wdata,
    output logic [NSLOT-1:0] ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic             dq_oe,
    output logic [DQ_W-1:0]  dq_out,
    output logic             rd_flash,
    output logic             rd_status,
    output logic [SLW-1:0]   slot_q
);

    logic flash_go;
    assign flash_go = sel && (kind == KIND_FLASH);

    // Per-slot chip enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n <= '1;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                ce_n[i] <= !(flash_go && slot_idx == SLW'(i));
            end
        end
    end

    // Strobes, latch enables and outgoing data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cle    <= 1'b0;
            ale    <= 1'b0;
            we_n   <= 1'b1;
            re_n   <= 1'b1;
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            cle    <= flash_go && cle_req;
            ale    <= flash_go && ale_req;
            we_n   <= !(flash_go && wr);
            re_n   <= !(flash_go && !wr);
            dq_oe  <= flash_go && wr;
            dq_out <= (flash_go && wr) ? wdata : '0;
        end
    end

    // Read-path selectors and the last selected slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_flash  <= 1'b0;
            rd_status <= 1'b0;
            slot_q    <= '0;
        end else begin
            rd_flash  <= flash_go && !wr;
            rd_status <= sel && status_hit;
            if (flash_go) begin
                slot_q <= slot_idx;
            end
        end
    end

    a_r1_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));
    a_r3_cle_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        cle |-> !we_n);
    a_r4_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    a_r5_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> (!dq_oe && !cle && !ale));
    a_r9_idle_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (&ce_n && we_n && re_n && !dq_oe));

endmodule

// File: rtl/nand_bus_decoder.sv
// Top of the NAND bus decoder: address decode, strobe registers,
// ready synchronisers and the host read-data mux.
// Assumes one host access at a time, held by hst_sel for its strobe.
module nand_bus_decoder
    import nbd_pkg::*;
#(
    parameter int AW    = 25,
    parameter int NSLOT = 2,
    parameter int DQ_W  = 8,
    parameter int RD_W  = 16,
    localparam int SLW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_sel,
    input  logic             hst_wr,
    input  logic [AW-1:0]    hst_addr,
    input  logic [DQ_W-1:0]  hst_wdata,
    output logic [RD_W-1:0]  hst_rdata,
    output logic [NSLOT-1:0] fl_ce_n,
    output logic             fl_cle,
    output logic             fl_ale,
    output logic             fl_we_n,
    output logic             fl_re_n,
    output logic [DQ_W-1:0]  fl_dq_out,
    output logic             fl_dq_oe,
    input  logic [DQ_W-1:0]  fl_dq_in,
    input  logic [NSLOT-1:0] fl_rdy
);

    nbd_kind_e        kind;
    logic [SLW-1:0]   slot_idx;
    logic             cle_req;
    logic             ale_req;
    logic             status_hit;
    logic             rd_flash;
    logic             rd_status;
    logic [SLW-1:0]   slot_q;
    logic [NSLOT-1:0] rdy_sync;

    nbd_addr_decode #(.AW(AW), .NSLOT(NSLOT)) u_dec (
        .addr       (hst_addr),
        .wr         (hst_wr),
        .kind       (kind),
        .slot_idx   (slot_idx),
        .cle_req    (cle_req),
        .ale_req    (ale_req),
        .status_hit (status_hit)
    );

    nbd_strobe_gen #(.NSLOT(NSLOT), .DQ_W(DQ_W)) u_stb (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (hst_sel),
        .wr         (hst_wr),
        .kind       (kind),
        .slot_idx   (slot_idx),
        .cle_req    (cle_req),
        .ale_req    (ale_req),
        .status_hit (status_hit),
        .wdata      (hst_wdata),
        .ce_n       (fl_ce_n),
        .cle        (fl_cle),
        .ale        (fl_ale),
        .we_n       (fl_we_n),
        .re_n       (fl_re_n),
        .dq_oe      (fl_dq_oe),
        .dq_out     (fl_dq_out),
        .rd_flash   (rd_flash),
        .rd_status  (rd_status),
        .slot_q     (slot_q)
    );

    nbd_rdy_sync #(.NSLOT(NSLOT)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy_async (fl_rdy),
        .rdy_sync  (rdy_sync)
    );

    // Host read data: flash byte, status word or zero.
    always_comb begin
        hst_rdata = '0;
        if (rd_flash) begin
            hst_rdata = {{(RD_W-DQ_W){1'b0}}, fl_dq_in};
        end else if (rd_status) begin
            hst_rdata = {{(RD_W-1){1'b0}}, rdy_sync[slot_q]};
        end
    end

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_re_n && !rd_status) |-> (hst_rdata == '0));
    a_r6_status_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |-> (&fl_ce_n));

endmodule

// File: tb/nand_bus_decoder_tb.sv
module nand_bus_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_sel = 1'b0;
    logic        hst_wr = 1'b0;
    logic [24:0] hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic [1:0]  fl_ce_n;
    logic        fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
    logic [7:0]  fl_dq_out;
    logic [7:0]  fl_dq_in = '0;
    logic [1:0]  fl_rdy = 2'b00;

    int n_chk = 0;
    int n_bad = 0;
    logic       m_slot = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    nand_bus_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
        .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_rdy(fl_rdy)
    );

    localparam logic [30:0] IDLE = {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 16'h0000};

    // Expected pin bundle {ce_n, cle, ale, we_n, re_n, oe, dq, rdata}.
    function automatic logic [30:0] expect_pins(logic [24:0] a, logic w,
                                                logic [7:0] wd, logic [7:0] din,
                                                logic sl, logic [1:0] rdy);
        logic [2:0]  code = a[24:22];
        logic [30:0] e = IDLE;
        if (code == 3'b010 || code == 3'b011) begin
            e[30:29] = code[0] ? 2'b01 : 2'b10;
            if (w) begin
                e[28] = a[5];
                e[27] = a[4] & ~a[5];
                e[26] = 1'b0;
                e[24] = 1'b1;
                e[23:16] = wd;
            end else begin
                e[25] = 1'b0;
                e[15:0] = {8'h00, din};
            end
        end else if (code == 3'b100 && !w && a[7:1] == 7'd1) begin
            e[15:0] = {15'd0, rdy[sl]};
        end
        return e;
    endfunction

    function automatic logic [30:0] actual_pins();
        return {fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, fl_dq_out, hst_rdata};
    endfunction

    task automatic check(string req, logic [30:0] exp_v);
        logic [30:0] act = actual_pins();
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp_v, $time);
        end
    endtask

    // Drive one access for `hold` cycles, checking pins each cycle, then idle.
    task automatic access(string req, logic [24:0] a, logic w, logic [7:0] wd, int hold);
        logic [30:0] e;
        hst_sel = 1'b1; hst_wr = w; hst_addr = a; hst_wdata = wd;
        fl_dq_in = 8'($urandom);
        e = expect_pins(a, w, wd, fl_dq_in, m_slot, fl_rdy);
        for (int k = 0; k < hold; k++) begin
            @(posedge clk); @(negedge clk);
            check(req, e);
        end
        if (a[24:22] == 3'b010 || a[24:22] == 3'b011) m_slot = a[22];
        hst_sel = 1'b0;
        @(posedge clk); @(negedge clk);
        check({req, " R9 idle"}, IDLE);
    endtask

    function automatic logic [24:0] mk(logic [2:0] code, logic [7:0] low);
        logic [24:0] r = 25'($urandom);
        r[24:22] = code;
        r[7:0] = low;
        return r;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        fl_rdy = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", IDLE);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 idle after reset", IDLE);

        // R7: status after reset follows slot 0 (not ready).
        access("R7 reset slot", mk(3'b100, 8'h02), 1'b0, 8'h00, 1);
        // R1 slot decode, R3 command write, R4 address write, R5 data.
        access("R1 R3 slot1 cmd", mk(3'b011, 8'h20), 1'b1, 8'h70, 1);
        access("R7 slot1 status", mk(3'b100, 8'h02), 1'b0, 8'h00, 1);
        access("R4 both bits", mk(3'b010, 8'h30), 1'b1, 8'h5A, 1);
        access("R4 ale write", mk(3'b010, 8'h10), 1'b1, 8'h01, 1);
        access("R5 data read", mk(3'b010, 8'h00), 1'b0, 8'h00, 1);
        access("R5 data write", mk(3'b011, 8'h00), 1'b1, 8'hC3, 1);
        access("R7 read sets slot", mk(3'b010, 8'h40), 1'b0, 8'h00, 1);
        access("R6 odd offset", mk(3'b100, 8'h03), 1'b0, 8'h00, 1);
        access("R6 other offset", mk(3'b100, 8'h04), 1'b0, 8'h00, 1);
        access("R6 reg write", mk(3'b100, 8'h02), 1'b1, 8'hFF, 1);
        access("R2 code 0", mk(3'b000, 8'h20), 1'b1, 8'h11, 1);
        access("R2 code 7 read", mk(3'b111, 8'h02), 1'b0, 8'h00, 1);
        access("R9 held write", mk(3'b011, 8'h10), 1'b1, 8'h9E, 4);

        // R8: hold a status read on slot 1 and toggle its ready pin.
        hst_sel = 1'b1; hst_wr = 1'b0; hst_addr = mk(3'b100, 8'h02);
        @(posedge clk); @(negedge clk);
        check("R8 before", expect_pins(hst_addr, 1'b0, 8'h0, 8'h0, m_slot, fl_rdy));
        fl_rdy[1] = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 one edge", {IDLE[30:16], 16'h0001});
        @(posedge clk); @(negedge clk);
        check("R8 two edges", {IDLE[30:16], 16'h0000});
        hst_sel = 1'b0;
        @(posedge clk); @(negedge clk);

        // Random mix of all codes and latch bits.
        for (int n = 0; n < 400; n++) begin
            logic [2:0] c = 3'($urandom);
            logic [7:0] lo = 8'($urandom);
            if (n % 50 == 0) begin
                fl_rdy = 2'($urandom);
                repeat (3) @(posedge clk);
                @(negedge clk);
            end
            if ($urandom % 3 == 0) lo[7:1] = 7'd1;
            access("R1 R2 R3 R4 R5 R6 random", mk(c, lo), 1'($urandom),
                   8'($urandom), 1 + int'($urandom % 2));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule